// File: doc/BRIEF.md
# Page-Crossing Buffer Address Generator

This block turns a buffer made of two separate 4 KB physical pages into a stream of byte addresses for an isochronous split transfer. A load pulse supplies both 20-bit page bases, a 12-bit starting offset, an initial page select and the number of beats. The block then offers one 32-bit address per beat on a valid/ready output stream. Each address is the selected page base in bits 31..12 and the current offset in bits 11..0.

Each accepted beat advances the offset by `BEAT_BYTES`, which may be 1, 2 or 4. When the offset runs past 0xFFF while page 0 is selected, the offset wraps and the block switches to the page 1 base. The page 1 base need not follow page 0 in memory. Only one such switch is possible. If a further beat would need a second crossing, the block raises a sticky error and stops offering addresses. The current offset, the page select and a done flag stay visible at the ports after the transfer ends.

Back-pressure rules for the output stream are as follows. `addr_valid` high with `addr_ready` low stalls the stream. During a stall the address and all state hold. A beat counts only in a cycle where both signals are high. `addr_valid` never depends on `addr_ready`.

Top module: `pgx_addr_gen`

## Requirements
- R1: While reset is asserted, `addr_valid`, `done`, `ovf_err`, `cur_page` and `cur_offset` are all zero.
- R2: The cycle after `load` is high, the outputs take these values:
  - `cur_offset` equals `load_offset` and `cur_page` equals `load_page`.
  - `ovf_err` is 0.
  - `addr_valid` is 1 exactly when `load_beats` is non-zero.
- R3: While `addr_valid` is high, `addr` equals the selected base in bits 31..12 and `cur_offset` in bits 11..0. The selected base is `base1` when `cur_page` is 1 and `base0` when it is 0.
- R4: An accepted beat (`addr_valid` and `addr_ready` both high) without a carry adds `BEAT_BYTES` to `cur_offset`. A stalled cycle (valid high, ready low) leaves `addr`, `addr_valid` and all state unchanged.
- R5: If an accepted beat carries the offset past 0xFFF while `cur_page` is 0, `cur_offset` becomes the sum modulo 4096 and `cur_page` becomes 1. Without a load, `cur_page` never returns from 1 to 0.
- R6: If an accepted beat that is not the last beat carries past 0xFFF while `cur_page` is 1, the following happens:
  - `ovf_err` becomes 1 and stays 1 until the next load.
  - `addr_valid` stays 0 for as long as `ovf_err` is 1.
  - `cur_offset` and `cur_page` keep their values.
- R7: After the last beat is accepted, the outputs settle as follows:
  - `done` becomes 1 and `addr_valid` becomes 0.
  - A carry on that last beat with page 1 selected raises no error. `cur_offset` wraps modulo 4096 and `cur_page` stays 1.
- R8: A `load` in the same cycle as an accepted beat takes priority. The next state is the freshly loaded one, and the beat does not advance it.
- R9: A load with `load_beats` equal to 0 sets `done` on the next cycle and keeps `addr_valid` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Start a new transfer with the load values |
| load_base0 | input | 20 | Page 0 base, physical address bits 31..12 |
| load_base1 | input | 20 | Page 1 base, physical address bits 31..12 |
| load_offset | input | 12 | Starting byte offset in the selected page |
| load_page | input | 1 | Starting page select (0 or 1) |
| load_beats | input | CNT_W | Number of beats in the transfer |
| addr_valid | output | 1 | An address is offered |
| addr_ready | input | 1 | Consumer accepts the offered address |
| addr | output | 32 | Physical byte address of the current beat |
| cur_offset | output | 12 | Current byte offset |
| cur_page | output | 1 | Current page select |
| done | output | 1 | All beats of the transfer were accepted |
| ovf_err | output | 1 | Sticky error: a second page crossing was needed |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a load and an accepted beat. The bench drives `load` while an address is being taken and expects the loaded state, with no trace of the beat. The second pair is a page carry and the final beat. The bench sets up short transfers that end exactly at the page edge, in both page 0 and page 1. It expects a clean `done` with a wrapped offset and no error. Random loads mid-transfer and random ready patterns add more of both coincidences, and a bench reference model judges every one of them.

// File: rtl/pgx_pkg.sv
package pgx_pkg;
  localparam int PAGE_W = 20;
  localparam int OFS_W  = 12;
  localparam int ADDR_W = PAGE_W + OFS_W;
  typedef logic [PAGE_W-1:0] page_t;
  typedef logic [OFS_W-1:0]  ofs_t;
endpackage

// File: rtl/pgx_offset_step.sv
module pgx_offset_step
  import pgx_pkg::*;
#(
  parameter int STEP = 4
) (
  input  ofs_t ofs,
  output ofs_t nxt,
  output logic carry
);
  localparam int SUM_W = OFS_W + 1;
  logic [SUM_W-1:0] sum;
  always_comb begin
    sum   = {1'b0, ofs} + SUM_W'(STEP);
    nxt   = sum[OFS_W-1:0];
    carry = sum[OFS_W];
  end
endmodule

// File: rtl/pgx_base_sel.sv
module pgx_base_sel
  import pgx_pkg::*;
(
  input  page_t base0,
  input  page_t base1,
  input  logic  sel,
  output page_t base
);
  page_t bases [2];
  assign bases[0] = base0;
  assign bases[1] = base1;
  assign base = bases[sel];
endmodule

// File: rtl/pgx_beat_ctr.sv
module pgx_beat_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             busy,
  output logic             last
);
  logic [CNT_W-1:0] cnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (load)     cnt_q <= load_val;
    else if (dec && busy) cnt_q <= cnt_q - CNT_W'(1);
  end
  assign busy = (cnt_q != '0);
  assign last = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/pgx_addr_gen.sv
module pgx_addr_gen
  import pgx_pkg::*;
#(
  parameter int BEAT_BYTES = 4,
  parameter int CNT_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [19:0]      load_base0,
  input  logic [19:0]      load_base1,
  input  logic [11:0]      load_offset,
  input  logic             load_page,
  input  logic [CNT_W-1:0] load_beats,
  output logic             addr_valid,
  input  logic             addr_ready,
  output logic [31:0]      addr,
  output logic [11:0]      cur_offset,
  output logic             cur_page,
  output logic             done,
  output logic             ovf_err
);
  page_t base0_q, base1_q, sel_base;
  ofs_t  ofs_q, ofs_nxt;
  logic  page_q, err_q, done_q;
  logic  carry, busy, last, accept;

  pgx_offset_step #(.STEP(BEAT_BYTES)) u_step (
    .ofs(ofs_q), .nxt(ofs_nxt), .carry(carry)
  );

  pgx_base_sel u_sel (
    .base0(base0_q), .base1(base1_q), .sel(page_q), .base(sel_base)
  );

  pgx_beat_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_beats),
    .dec(accept), .busy(busy), .last(last)
  );

  assign addr_valid = busy && !err_q;
  assign accept     = addr_valid && addr_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base0_q <= '0;
      base1_q <= '0;
      ofs_q   <= '0;
      page_q  <= 1'b0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
    end else if (load) begin
      base0_q <= load_base0;
      base1_q <= load_base1;
      ofs_q   <= load_offset;
      page_q  <= load_page;
      err_q   <= 1'b0;
      done_q  <= (load_beats == '0);
    end else if (accept) begin
      if (!carry) begin
        ofs_q <= ofs_nxt;
      end else if (!page_q) begin
        ofs_q  <= ofs_nxt;
        page_q <= 1'b1;
      end else if (last) begin
        ofs_q <= ofs_nxt;
      end else begin
        err_q <= 1'b1;
      end
      if (last) done_q <= 1'b1;
    end
  end

  assign addr       = {sel_base, ofs_q};
  assign cur_offset = ofs_q;
  assign cur_page   = page_q;
  assign done       = done_q;
  assign ovf_err    = err_q;
endmodule

// File: rtl/pgx_checker.sv
module pgx_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        load,
  input logic [11:0] load_offset,
  input logic        addr_valid,
  input logic        addr_ready,
  input logic [31:0] addr,
  input logic [11:0] cur_offset,
  input logic        cur_page,
  input logic        done,
  input logic        ovf_err
);
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cur_offset == $past(load_offset)) && !ovf_err); // R2
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !addr_ready && !load) |=> (addr_valid && $stable(addr))); // R4
  AST_PAGE_ONE_WAY: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_page && !load) |=> cur_page); // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_err && !load) |=> ovf_err); // R6
  AST_ERR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |-> !addr_valid); // R6
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !addr_valid); // R7
endmodule

bind pgx_addr_gen pgx_checker u_chk (.*);

// File: tb/tb_pgx_addr_gen.sv
module tb_pgx_addr_gen;
  localparam int BEAT = 4;
  localparam int CW   = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, load, load_page, addr_ready;
  logic [19:0]   load_base0, load_base1;
  logic [11:0]   load_offset;
  logic [CW-1:0] load_beats;
  logic          addr_valid, cur_page, done, ovf_err;
  logic [31:0]   addr;
  logic [11:0]   cur_offset;

  pgx_addr_gen #(.BEAT_BYTES(BEAT), .CNT_W(CW)) dut (.*);

  int errors = 0;
  int checks = 0;

  logic [19:0]   m_b0 = '0, m_b1 = '0;
  logic [11:0]   m_ofs = '0;
  logic          m_pg = 1'b0, m_err = 1'b0, m_done = 1'b0;
  logic [CW-1:0] m_rem = '0;

  function automatic logic m_valid();
    return (m_rem != '0) && !m_err;
  endfunction

  function automatic logic [31:0] m_addr();
    return {(m_pg ? m_b1 : m_b0), m_ofs};
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk(addr_valid == m_valid(), tag, "addr_valid", 32'(addr_valid), 32'(m_valid()));
    if (m_valid()) chk(addr == m_addr(), tag, "addr", addr, m_addr());
    chk(cur_offset == m_ofs, tag, "cur_offset", 32'(cur_offset), 32'(m_ofs));
    chk(cur_page == m_pg, tag, "cur_page", 32'(cur_page), 32'(m_pg));
    chk(done == m_done, tag, "done", 32'(done), 32'(m_done));
    chk(ovf_err == m_err, tag, "ovf_err", 32'(ovf_err), 32'(m_err));
  endtask

  task automatic step(input bit ld, input logic [19:0] b0, input logic [19:0] b1,
                      input logic [11:0] o, input bit pg, input logic [CW-1:0] n,
                      input bit rdy, input string tag);
    logic [12:0] sum;
    logic        lst;
    @(negedge clk);
    compare(tag);
    load = ld; load_base0 = b0; load_base1 = b1; load_offset = o;
    load_page = pg; load_beats = n; addr_ready = rdy;
    if (ld) begin
      m_b0 = b0; m_b1 = b1; m_ofs = o; m_pg = pg; m_rem = n;
      m_err = 1'b0; m_done = (n == '0);
    end else if (m_valid() && rdy) begin
      sum = {1'b0, m_ofs} + 13'(BEAT);
      lst = (m_rem == CW'(1));
      m_rem = m_rem - CW'(1);
      if (!sum[12]) m_ofs = sum[11:0];
      else if (!m_pg) begin m_ofs = sum[11:0]; m_pg = 1'b1; end
      else if (lst) m_ofs = sum[11:0];
      else m_err = 1'b1;
      if (lst) m_done = 1'b1;
    end
  endtask

  task automatic idle(input bit rdy, input string tag);
    step(1'b0, '0, '0, '0, 1'b0, '0, rdy, tag);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; load = 1'b0; load_page = 1'b0; addr_ready = 1'b0;
    load_base0 = '0; load_base1 = '0; load_offset = '0; load_beats = '0;
    repeat (2) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;

    // R2 / R5 / R3: cross from page 0 into non-contiguous page 1
    step(1'b1, 20'h12345, 20'hABCDE, 12'hFFC, 1'b0, 8'd3, 1'b0, "R2");
    repeat (3) idle(1'b1, "R5");
    repeat (2) idle(1'b1, "R7");

    // R6: second crossing needed with beats left
    step(1'b1, 20'h00011, 20'h00022, 12'hFF8, 1'b1, 8'd4, 1'b1, "R6");
    repeat (5) idle(1'b1, "R6");

    // R4: stalls hold, then beats advance
    step(1'b1, 20'h0F0F0, 20'h0A0A0, 12'h100, 1'b0, 8'd2, 1'b0, "R4");
    repeat (3) idle(1'b0, "R4");
    repeat (3) idle(1'b1, "R4");

    // R7: page 1 carry on the final beat is clean
    step(1'b1, 20'h11111, 20'h22222, 12'hFFC, 1'b1, 8'd1, 1'b1, "R7");
    repeat (2) idle(1'b1, "R7");

    // R7: page 0 carry on the final beat
    step(1'b1, 20'h33333, 20'h44444, 12'hFFC, 1'b0, 8'd1, 1'b1, "R7");
    repeat (2) idle(1'b1, "R7");

    // R8: load coincides with an accepted beat
    step(1'b1, 20'h55555, 20'h66666, 12'h010, 1'b0, 8'd5, 1'b1, "R8");
    idle(1'b1, "R8");
    step(1'b1, 20'h77777, 20'h88888, 12'h800, 1'b1, 8'd2, 1'b1, "R8");
    repeat (3) idle(1'b1, "R8");

    // R9: zero-beat load
    step(1'b1, 20'h99999, 20'hAAAAA, 12'h444, 1'b0, 8'd0, 1'b1, "R9");
    repeat (2) idle(1'b1, "R9");

    // R3: random mix
    for (int i = 0; i < 4000; i++) begin
      bit ld;
      logic [11:0] o;
      ld = (($urandom % 40) == 0) || (!m_valid() && (($urandom % 3) == 0));
      if ($urandom % 2)
        o = (12'hFFF & ~12'(BEAT - 1)) - 12'(($urandom % 8) * BEAT);
      else
        o = 12'($urandom) & ~12'(BEAT - 1);
      step(ld, 20'($urandom), 20'($urandom), o, 1'($urandom),
           CW'($urandom % 24), (($urandom % 3) != 0), "R3");
    end
    @(negedge clk);
    compare("R3");
    finish_run();
  end
endmodule